// File: doc/BRIEF.md
# Packet Trace Match and Filter Unit

This unit sits on the receive side of one switch port. It watches the word stream of every arriving packet and looks at the first 160 bits. Those bits may lie in the header or run into the payload. The unit tests them against up to four programmable patterns. Each pattern has its own care mask, enable and action. From the result the unit issues one verdict per packet: forward only, forward plus a duplicate to a configured trace port, or discard.

Each port carries its own instance, and instances never interact. The window is checked word by word as it arrives, so no copy of the 160 bits is held. The verdict appears one cycle after the beat that completes the window. For a packet shorter than 160 bits, it appears one cycle after the end-of-packet beat. The fabric can therefore make its decision as soon as the window has been received.

Top module: `ptm_trace_filter`

## Requirements
- R1: While reset is held and after it is released with no traffic, `vrd_valid`, `vrd_fwd`, `vrd_trace`, `vrd_drop` and `vrd_port` are all zero.
- R2: The window is the first NUM_BEATS = 160/WORD_W accepted beats, counted from the beat with `in_sop`. The first beat maps to window bits 159 down to 160-WORD_W, and later beats map to successively lower bits. A comparator matches when every window bit whose care bit is 1 equals its value bit. Care bits that are 0 are never compared.
- R3: `vrd_valid` is high for exactly one cycle per packet. That cycle is the one after the beat that completes the window, or the one after the `in_eop` beat if the packet ends sooner. Beats after the window never change the verdict or raise `vrd_valid` again.
- R4: With `trace_en`=1, suppose at least one enabled comparator with action bit 0 matches and no enabled matching comparator has action bit 1. The verdict is then `vrd_fwd`=1, `vrd_trace`=1, `vrd_drop`=0.
- R5: With `trace_en`=1, an enabled matching comparator whose action bit is 1 gives `vrd_drop`=1, `vrd_fwd`=0, `vrd_trace`=0.
- R6: When several enabled comparators match and any of them has action bit 1, the packet is dropped. Only one trace copy is ever requested per packet.
- R7: When no enabled comparator matches, or `trace_en`=0, the verdict is `vrd_fwd`=1, `vrd_trace`=0, `vrd_drop`=0.
- R8: A comparator whose enable bit is 0 never affects the verdict, whatever its value, mask and action.
- R9: In a packet shorter than the window, a missing bit whose care bit is 1 counts as a mismatch. A pattern whose care bits are all 0 over the missing part can still match.
- R10: A beat with `in_sop` discards any partial comparison state and starts a new window. This holds even if the previous packet never ended. Beats accepted outside a packet (before any `in_sop`, or after `in_eop`) produce no verdict.
- R11: `vrd_port` equals `trace_port`, sampled in the window-closing beat, when `vrd_trace`=1. It is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet word is present this cycle |
| in_sop | input | 1 | This word starts a packet |
| in_eop | input | 1 | This word ends a packet |
| in_data | input | WORD_W | Packet word |
| trace_en | input | 1 | Enables match actions for this port |
| trace_port | input | PORT_W | Port that receives trace copies |
| cmp_en | input | NUM_CMP | Per-comparator enable |
| cmp_drop | input | NUM_CMP | Per-comparator action: 0 copy to trace, 1 drop |
| cmp_value | input | NUM_CMP*160 | Patterns; comparator i occupies bits [i*160 +: 160] |
| cmp_care | input | NUM_CMP*160 | Care masks, same layout as `cmp_value` |
| vrd_valid | output | 1 | Verdict strobe, one cycle per packet |
| vrd_fwd | output | 1 | Route normally |
| vrd_trace | output | 1 | Also send a copy to `vrd_port` |
| vrd_drop | output | 1 | Discard the packet |
| vrd_port | output | PORT_W | Trace destination |

## Verification
A vector table drives full-window packets through combinations that separate each path. The combinations are a lone copy match, a lone drop match, copy and drop matching together, no match, tracing switched off, and every comparator disabled while its pattern matches. A comparator is also set up to disagree in one cared bit, which shows that a single-bit difference defeats a match. A packet longer than the window shows that the verdict is timed by the window and that trailing words are ignored. Directed packets cover the short-packet rule, once with missing bits cared and once with them masked. Further directed packets cover a start marker that abandons an unfinished packet, stray words outside any packet, and the reported trace port following its configuration.

// File: rtl/ptm_pkg.sv
`timescale 1ns/1ps
package ptm_pkg;
    localparam int WIN_BITS = 160;

    typedef struct packed {
        logic valid;
        logic fwd;
        logic trace;
        logic drop;
    } verdict_flags_t;
endpackage

// File: rtl/ptm_beat_tracker.sv
`timescale 1ns/1ps
module ptm_beat_tracker #(
    parameter int NUM_BEATS = 5,
    localparam int IDX_W = $clog2(NUM_BEATS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             beat_live,
    output logic             beat_first,
    output logic [IDX_W-1:0] beat_idx,
    output logic             win_close
);
    typedef struct packed {
        logic             in_pkt;
        logic             closed;
        logic [IDX_W-1:0] idx;
    } trk_state_t;

    trk_state_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        beat_first = in_valid && in_sop;
        beat_idx   = beat_first ? '0 : st_q.idx;
        beat_live  = in_valid && (beat_first || (st_q.in_pkt && !st_q.closed));
        win_close  = beat_live && (in_eop || (beat_idx == IDX_W'(NUM_BEATS - 1)));
        if (beat_live) begin
            st_d.idx    = beat_idx + 1'b1;
            st_d.closed = win_close;
        end
        if (in_valid && (beat_first || st_q.in_pkt)) begin
            st_d.in_pkt = !in_eop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= IDX_W'(NUM_BEATS));

    p_single_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.closed && !(in_valid && in_sop)) |-> !win_close);

    p_sop_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop) |=> (st_q.idx == IDX_W'(1)));
endmodule

// File: rtl/ptm_cmp_lane.sv
`timescale 1ns/1ps
module ptm_cmp_lane
    import ptm_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_BEATS = 5,
    localparam int IDX_W = $clog2(NUM_BEATS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                beat_live,
    input  logic                beat_first,
    input  logic [IDX_W-1:0]    beat_idx,
    input  logic [WORD_W-1:0]   beat_data,
    input  logic [WIN_BITS-1:0] lane_value,
    input  logic [WIN_BITS-1:0] lane_care,
    input  logic                lane_en,
    output logic                lane_hit
);
    typedef struct packed {
        logic ok;
    } lane_state_t;

    lane_state_t st_q, st_d;

    logic [WORD_W-1:0] val_w  [NUM_BEATS];
    logic [WORD_W-1:0] care_w [NUM_BEATS];
    logic [NUM_BEATS-1:0] care_nz;

    for (genvar g = 0; g < NUM_BEATS; g++) begin : g_words
        assign val_w[g]   = lane_value[WIN_BITS-1-g*WORD_W -: WORD_W];
        assign care_w[g]  = lane_care[WIN_BITS-1-g*WORD_W -: WORD_W];
        assign care_nz[g] = |care_w[g];
    end

    logic [IDX_W-1:0] sel;
    logic             word_ok;
    logic             cur_ok;
    logic             tail_clear;

    always_comb begin
        st_d    = st_q;
        sel     = (beat_idx < IDX_W'(NUM_BEATS)) ? beat_idx : '0;
        word_ok = (((beat_data ^ val_w[sel]) & care_w[sel]) == '0);
        cur_ok  = (beat_first ? 1'b1 : st_q.ok) && word_ok;
        tail_clear = 1'b1;
        for (int g = 0; g < NUM_BEATS; g++) begin
            if ((g > int'(sel)) && care_nz[g]) begin
                tail_clear = 1'b0;
            end
        end
        lane_hit = lane_en && cur_ok && tail_clear;
        if (beat_live) begin
            st_d.ok = cur_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_miss_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ok && !(beat_live && beat_first)) |=> !st_q.ok);
endmodule

// File: rtl/ptm_verdict.sv
`timescale 1ns/1ps
module ptm_verdict
    import ptm_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int PORT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_close,
    input  logic [NUM_CMP-1:0] lane_hit,
    input  logic [NUM_CMP-1:0] cmp_drop,
    input  logic               trace_en,
    input  logic [PORT_W-1:0]  trace_port,
    output logic               vrd_valid,
    output logic               vrd_fwd,
    output logic               vrd_trace,
    output logic               vrd_drop,
    output logic [PORT_W-1:0]  vrd_port
);
    typedef struct packed {
        verdict_flags_t    flags;
        logic [PORT_W-1:0] port;
    } vrd_state_t;

    vrd_state_t st_q, st_d;
    logic any_hit;
    logic any_drop;

    always_comb begin
        st_d     = '0;
        any_hit  = |lane_hit;
        any_drop = |(lane_hit & cmp_drop);
        if (win_close) begin
            st_d.flags.valid = 1'b1;
            if (trace_en && any_drop) begin
                st_d.flags.drop = 1'b1;
            end else if (trace_en && any_hit) begin
                st_d.flags.fwd   = 1'b1;
                st_d.flags.trace = 1'b1;
                st_d.port        = trace_port;
            end else begin
                st_d.flags.fwd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vrd_valid = st_q.flags.valid;
    assign vrd_fwd   = st_q.flags.fwd;
    assign vrd_trace = st_q.flags.trace;
    assign vrd_drop  = st_q.flags.drop;
    assign vrd_port  = st_q.port;

    p_drop_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_drop |-> (!vrd_fwd && !vrd_trace));

    p_trace_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_trace |-> vrd_fwd);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !vrd_valid |-> (!vrd_fwd && !vrd_trace && !vrd_drop && vrd_port == '0));

    p_port_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vrd_trace |-> (vrd_port == '0));
endmodule

// File: rtl/ptm_trace_filter.sv
`timescale 1ns/1ps
module ptm_trace_filter
    import ptm_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NUM_CMP = 4,
    parameter int PORT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic [WORD_W-1:0]           in_data,
    input  logic                        trace_en,
    input  logic [PORT_W-1:0]           trace_port,
    input  logic [NUM_CMP-1:0]          cmp_en,
    input  logic [NUM_CMP-1:0]          cmp_drop,
    input  logic [NUM_CMP*WIN_BITS-1:0] cmp_value,
    input  logic [NUM_CMP*WIN_BITS-1:0] cmp_care,
    output logic                        vrd_valid,
    output logic                        vrd_fwd,
    output logic                        vrd_trace,
    output logic                        vrd_drop,
    output logic [PORT_W-1:0]           vrd_port
);
    localparam int NUM_BEATS = WIN_BITS / WORD_W;
    localparam int IDX_W     = $clog2(NUM_BEATS + 1);

    logic             beat_live;
    logic             beat_first;
    logic [IDX_W-1:0] beat_idx;
    logic             win_close;
    logic [NUM_CMP-1:0] lane_hit;

    ptm_beat_tracker #(.NUM_BEATS(NUM_BEATS)) i_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .beat_live  (beat_live),
        .beat_first (beat_first),
        .beat_idx   (beat_idx),
        .win_close  (win_close)
    );

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_lane
        ptm_cmp_lane #(.WORD_W(WORD_W), .NUM_BEATS(NUM_BEATS)) i_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .beat_live  (beat_live),
            .beat_first (beat_first),
            .beat_idx   (beat_idx),
            .beat_data  (in_data),
            .lane_value (cmp_value[c*WIN_BITS +: WIN_BITS]),
            .lane_care  (cmp_care[c*WIN_BITS +: WIN_BITS]),
            .lane_en    (cmp_en[c]),
            .lane_hit   (lane_hit[c])
        );
    end

    ptm_verdict #(.NUM_CMP(NUM_CMP), .PORT_W(PORT_W)) i_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_close  (win_close),
        .lane_hit   (lane_hit),
        .cmp_drop   (cmp_drop),
        .trace_en   (trace_en),
        .trace_port (trace_port),
        .vrd_valid  (vrd_valid),
        .vrd_fwd    (vrd_fwd),
        .vrd_trace  (vrd_trace),
        .vrd_drop   (vrd_drop),
        .vrd_port   (vrd_port)
    );

    p_strobe_after_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_valid |-> $past(in_valid));

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !trace_en) |=> !(vrd_trace || vrd_drop));
endmodule

// File: tb/test_ptm_trace_filter.sv
`timescale 1ns/1ps
module test_ptm_trace_filter;
    localparam int W  = 32;
    localparam int NC = 4;
    localparam int PW = 4;
    localparam int WB = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [W-1:0] in_data = '0;
    logic trace_en = 1'b0;
    logic [PW-1:0] trace_port = '0;
    logic [NC-1:0] cmp_en = '0, cmp_drop = '0;
    logic [NC*WB-1:0] cmp_value = '0, cmp_care = '0;
    logic vrd_valid, vrd_fwd, vrd_trace, vrd_drop;
    logic [PW-1:0] vrd_port;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ptm_trace_filter #(.WORD_W(W), .NUM_CMP(NC), .PORT_W(PW)) i_ptm_trace_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .trace_en(trace_en), .trace_port(trace_port), .cmp_en(cmp_en),
        .cmp_drop(cmp_drop), .cmp_value(cmp_value), .cmp_care(cmp_care),
        .vrd_valid(vrd_valid), .vrd_fwd(vrd_fwd), .vrd_trace(vrd_trace),
        .vrd_drop(vrd_drop), .vrd_port(vrd_port)
    );

    // Row: len[27:24] seed[23:16] en[15:12] drop[11:8] match[7:4] trace_en[3] exp fwd,trace,drop[2:0]
    localparam int NROWS = 9;
    localparam logic [27:0] TBL [NROWS] = '{
        {4'd5, 8'h11, 4'b0001, 4'b0000, 4'b0001, 1'b1, 3'b110},  // R4 copy
        {4'd5, 8'h22, 4'b0010, 4'b0010, 4'b0010, 1'b1, 3'b001},  // R5 drop
        {4'd5, 8'h33, 4'b0011, 4'b0010, 4'b0011, 1'b1, 3'b001},  // R6 drop wins
        {4'd5, 8'h44, 4'b1111, 4'b0000, 4'b0000, 1'b1, 3'b100},  // R7 no match, R2 one cared bit
        {4'd5, 8'h55, 4'b0001, 4'b0000, 4'b0001, 1'b0, 3'b100},  // R7 tracing off
        {4'd5, 8'h66, 4'b0000, 4'b1111, 4'b1111, 1'b1, 3'b100},  // R8 all disabled
        {4'd8, 8'h77, 4'b0100, 4'b0000, 4'b0100, 1'b1, 3'b110},  // R3 long packet
        {4'd5, 8'h88, 4'b1001, 4'b0001, 4'b1000, 1'b1, 3'b110},  // R6 unmatched drop ignored
        {4'd7, 8'h99, 4'b1000, 4'b1000, 4'b1000, 1'b1, 3'b001}   // R3 R5 long drop
    };

    function automatic string row_req(input int r);
        case (r)
            0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R2";
            4: return "R7"; 5: return "R8"; 6: return "R3"; 7: return "R6";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [W-1:0] pkt_word(input logic [7:0] s, input int j);
        return {s, 8'(j), ~s, 8'hA5};
    endfunction

    function automatic logic [WB-1:0] pkt_win(input logic [7:0] s);
        logic [WB-1:0] w;
        for (int j = 0; j < 5; j++) w[WB-1-32*j -: 32] = pkt_word(s, j);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] en, input logic [3:0] drp, input logic [3:0] sel,
                           input logic ten, input logic [7:0] seed, input logic [WB-1:0] care);
        cmp_en = en;
        cmp_drop = drp;
        trace_en = ten;
        for (int i = 0; i < NC; i++) begin
            cmp_value[i*WB +: WB] = sel[i] ? pkt_win(seed) : (pkt_win(seed) ^ (WB'(1) << (100 + i)));
            cmp_care[i*WB +: WB]  = care;
        end
    endtask

    // Sends one packet starting at a negedge; checks the strobe after every beat.
    task automatic run_pkt(input int len, input logic [7:0] seed, input int close_at,
                           input logic [2:0] exp, input string req);
        logic [31:0] act, want;
        for (int j = 0; j < len; j++) begin
            in_valid = 1'b1;
            in_sop = (j == 0);
            in_eop = (j == len - 1);
            in_data = pkt_word(seed, j);
            @(negedge clk);
            act = {23'd0, vrd_valid, vrd_fwd, vrd_trace, vrd_drop, 1'b0, vrd_port};
            if (j == close_at)
                want = {23'd0, 1'b1, exp, 1'b0, (exp[1] ? trace_port : 4'd0)};
            else
                want = '0;
            chk(act == want, req, act, want);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(negedge clk);
        chk(!vrd_valid, req, {31'd0, vrd_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [WB-1:0] all_care;
        all_care = '1;
        repeat (3) @(negedge clk);
        // R1: outputs during and after reset
        chk({vrd_valid, vrd_fwd, vrd_trace, vrd_drop, vrd_port} == '0, "R1",
            {24'd0, vrd_valid, vrd_fwd, vrd_trace, vrd_drop, vrd_port}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({vrd_valid, vrd_fwd, vrd_trace, vrd_drop, vrd_port} == '0, "R1",
            {24'd0, vrd_valid, vrd_fwd, vrd_trace, vrd_drop, vrd_port}, 32'd0);

        trace_port = 4'd9;
        for (int r = 0; r < NROWS; r++) begin
            set_cfg(TBL[r][15:12], TBL[r][11:8], TBL[r][7:4], TBL[r][3], TBL[r][23:16], all_care);
            run_pkt(int'(TBL[r][27:24]), TBL[r][23:16], 4, TBL[r][2:0], row_req(r));
        end

        // R9: short packet, missing bits cared -> no match
        set_cfg(4'b0001, 4'b0000, 4'b0001, 1'b1, 8'hA1, all_care);
        run_pkt(3, 8'hA1, 2, 3'b100, "R9");
        // R9: missing bits masked out -> copy, verdict after eop beat (R3)
        set_cfg(4'b0001, 4'b0000, 4'b0001, 1'b1, 8'hA2, {{96{1'b1}}, 64'd0});
        run_pkt(3, 8'hA2, 2, 3'b110, "R9");
        // R3: single-beat packet closes immediately
        set_cfg(4'b0001, 4'b0001, 4'b0001, 1'b1, 8'hA3, {{32{1'b1}}, 128'd0});
        run_pkt(1, 8'hA3, 0, 3'b001, "R3");

        // R10: unfinished packet abandoned by a new start marker
        set_cfg(4'b0001, 4'b0000, 4'b0001, 1'b1, 8'hB0, all_care);
        for (int j = 0; j < 2; j++) begin
            in_valid = 1'b1; in_sop = (j == 0); in_eop = 1'b0;
            in_data = pkt_word(8'hC0, j);
            @(negedge clk);
            chk(!vrd_valid, "R10", {31'd0, vrd_valid}, 32'd0);
        end
        run_pkt(5, 8'hB0, 4, 3'b110, "R10");
        // R10: stray beats outside any packet
        for (int j = 0; j < 6; j++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (j == 5);
            in_data = pkt_word(8'hB0, j);
            @(negedge clk);
            chk(!vrd_valid, "R10", {31'd0, vrd_valid}, 32'd0);
        end
        in_valid = 1'b0; in_eop = 1'b0;

        // R11: reported port follows configuration
        trace_port = 4'd3;
        set_cfg(4'b0010, 4'b0000, 4'b0010, 1'b1, 8'hD4, all_care);
        run_pkt(5, 8'hD4, 4, 3'b110, "R11");
        set_cfg(4'b0010, 4'b0000, 4'b0000, 1'b1, 8'hD5, all_care);
        run_pkt(5, 8'hD5, 4, 3'b100, "R11");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule